// File: doc/BRIEF.md
# Scaled-compare real-time counter

This block is a real-time counter peripheral on a simple 32-bit register port. A 64-bit count advances by one on each qualified low-rate tick pulse while the run bit in the control register is set. The count is read and written as two 32-bit words, and a 4-bit power-of-two scale selects which 32-bit window of the count is compared against a 32-bit compare register. A 32-bit compare value can therefore reach thresholds anywhere in the 64-bit time range, with a resolution set by the scale.

While the scaled count is greater than or equal to the compare value, a level interrupt is asserted. The same condition is visible as a read-only pending flag in the control register. The interrupt is cleared by moving the threshold above the scaled count or by loading a smaller count. Software loads a new time by writing the upper word first and then the lower word, normally with the counter stopped.

Top module: `scaled_rtc`

## Requirements
- R1: After reset the count reads 0, the control register reads 0 (scale 0, stopped), the compare register reads 0xFFFFFFFF, and `irq_o` is 0.
- R2: The control register at byte offset 0x40 holds the scale in bits [3:0] and the run bit in bit 12, and reports the pending flag in bit 28. The pending flag always equals `irq_o`, and writing bit 28 has no effect on it. All other control bits read 0.
- R3: While the run bit is 1, each cycle with `tick_i` high adds one to the count. When the run bit is 0 or `tick_i` is low, the count holds its value.
- R4: The low word of the count is at offset 0x48 and the high word at 0x4C. Each word can be written and read back on its own, and writing the high word and then the low word loads the full 64-bit value.
- R5: A write to either count word in the same cycle as a qualified tick loads the written word and skips the increment for that cycle. The other word keeps its value.
- R6: When the count is all ones, a qualified tick wraps it to zero.
- R7: Offset 0x50 reads count bits [scale+31:scale]. Writes to 0x50 change nothing.
- R8: The compare register is at 0x60. `irq_o` is high, with no register delay, exactly when the scaled count is greater than or equal to the compare value.
- R9: `irq_o` falls once the compare value is raised above the scaled count or once the count is lowered below the threshold.
- R10: Reads at unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse that qualifies a count increment |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte offset of the accessed register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt: scaled count has reached the compare value |

## Verification
The in-line assertions check on every cycle that the count holds when neither a tick nor a write qualifies it and steps by exactly one (wrapping) when one does. They also check that a word write overrides an increment and leaves the other word alone, that the control fields change only on a control write, that the pending flag tracks the interrupt line, and that raising the threshold clears the interrupt. Only the bench scenarios can show the absolute values: the reset contents, the scaled window at several scale settings, the interrupt rising as ticks cross the threshold, the wrap from all ones, and unmapped or read-only writes leaving every register unchanged.

// File: rtl/scaled_rtc_pkg.sv
`timescale 1ns/1ps
package scaled_rtc_pkg;

   // register byte offsets
   localparam int unsigned OFS_CFG    = 32'h40;
   localparam int unsigned OFS_CNT_LO = 32'h48;
   localparam int unsigned OFS_CNT_HI = 32'h4C;
   localparam int unsigned OFS_SCALED = 32'h50;
   localparam int unsigned OFS_CMP    = 32'h60;

   // control register field positions
   localparam int unsigned CFG_RUN_BIT  = 12;
   localparam int unsigned CFG_PEND_BIT = 28;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CFG,
      SEL_CNT_LO,
      SEL_CNT_HI,
      SEL_SCALED,
      SEL_CMP
   } reg_sel_e;

endpackage

// File: rtl/scaled_rtc_decode.sv
`timescale 1ns/1ps
module scaled_rtc_decode
   import scaled_rtc_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   generate
      if (ADDR_W < 7) begin : g_chk_addr
         $error("scaled_rtc_decode: ADDR_W must reach offset 0x60");
      end
   endgenerate

   always_comb begin
      if (addr_i == ADDR_W'(OFS_CFG))
         sel_o = SEL_CFG;
      else if (addr_i == ADDR_W'(OFS_CNT_LO))
         sel_o = SEL_CNT_LO;
      else if (addr_i == ADDR_W'(OFS_CNT_HI))
         sel_o = SEL_CNT_HI;
      else if (addr_i == ADDR_W'(OFS_SCALED))
         sel_o = SEL_SCALED;
      else if (addr_i == ADDR_W'(OFS_CMP))
         sel_o = SEL_CMP;
      else
         sel_o = SEL_NONE;
   end

endmodule

// File: rtl/scaled_rtc_ctrl.sv
`timescale 1ns/1ps
module scaled_rtc_ctrl
   import scaled_rtc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SCALE_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cfg_we_i,
   input  logic               cmp_we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [SCALE_W-1:0] scale_o,
   output logic               run_o,
   output logic [DATA_W-1:0]  cmp_o
);

   generate
      if (SCALE_W < 1 || SCALE_W > int'(CFG_RUN_BIT)) begin : g_chk_scale
         $error("scaled_rtc_ctrl: scale field overlaps the run bit");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scale_o <= '0;
         run_o   <= 1'b0;
      end else if (cfg_we_i) begin
         scale_o <= wdata_i[SCALE_W-1:0];
         run_o   <= wdata_i[CFG_RUN_BIT];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cmp_o <= '1;
      else if (cmp_we_i)
         cmp_o <= wdata_i;
   end

   // R2
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_we_i |=> ($stable(scale_o) && $stable(run_o)));

   // R8
   cmp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_we_i |=> (cmp_o == $past(wdata_i)));

endmodule

// File: rtl/scaled_rtc_count.sv
`timescale 1ns/1ps
module scaled_rtc_count #(
   parameter int DATA_W  = 32,
   parameter int COUNT_W = 64
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               lo_we_i,
   input  logic               hi_we_i,
   input  logic               inc_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [COUNT_W-1:0] count_o
);

   localparam int HI_W = COUNT_W - DATA_W;

   generate
      if (COUNT_W != 2 * DATA_W) begin : g_chk_width
         $error("scaled_rtc_count: count must be two data words wide");
      end
   endgenerate

   logic [DATA_W-1:0] lo_q;
   logic [HI_W-1:0]   hi_q;
   logic              any_we;

   assign any_we  = lo_we_i | hi_we_i;
   assign count_o = {hi_q, lo_q};

   // a word write takes precedence over an increment in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (any_we) begin
         if (lo_we_i) lo_q <= wdata_i;
         if (hi_we_i) hi_q <= HI_W'(wdata_i);
      end else if (inc_i) begin
         {hi_q, lo_q} <= {hi_q, lo_q} + COUNT_W'(1);
      end
   end

   // R3
   count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!any_we && !inc_i) |=> $stable(count_o));

   // R3 R6
   count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!any_we && inc_i) |=> (count_o == $past(count_o) + COUNT_W'(1)));

   // R5
   lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lo_we_i && !hi_we_i) |=> ((count_o[DATA_W-1:0] == $past(wdata_i)) &&
                                 (count_o[COUNT_W-1:DATA_W] == $past(count_o[COUNT_W-1:DATA_W]))));

   // R5
   hi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hi_we_i && !lo_we_i) |=> ((count_o[COUNT_W-1:DATA_W] == $past(wdata_i)) &&
                                 (count_o[DATA_W-1:0] == $past(count_o[DATA_W-1:0]))));

endmodule

// File: rtl/scaled_rtc_scale.sv
`timescale 1ns/1ps
module scaled_rtc_scale #(
   parameter int DATA_W         = 32,
   parameter int COUNT_W        = 64,
   parameter int SCALE_W        = 4,
   parameter bit USE_LOG_SHIFT  = 1'b1
) (
   input  logic [COUNT_W-1:0] count_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [DATA_W-1:0]  cmp_i,
   output logic [DATA_W-1:0]  scaled_o,
   output logic               match_o
);

   localparam int MAX_SHIFT = (1 << SCALE_W) - 1;

   generate
      if (DATA_W + MAX_SHIFT > COUNT_W) begin : g_chk_window
         $error("scaled_rtc_scale: largest scale runs past the count");
      end
   endgenerate

   logic [COUNT_W-1:0] shifted;

   generate
      if (USE_LOG_SHIFT) begin : g_log
         // one mux stage per scale bit, shift distances 1, 2, 4, ...
         logic [COUNT_W-1:0] stage [SCALE_W+1];
         assign stage[0] = count_i;
         for (genvar s = 0; s < SCALE_W; s++) begin : g_stage
            assign stage[s+1] = scale_i[s] ? (stage[s] >> (1 << s)) : stage[s];
         end
         assign shifted = stage[SCALE_W];
      end else begin : g_flat
         assign shifted = count_i >> scale_i;
      end
   endgenerate

   logic unused_hi;
   assign unused_hi = ^shifted[COUNT_W-1:DATA_W];

   assign scaled_o = shifted[DATA_W-1:0];
   assign match_o  = (scaled_o >= cmp_i);

endmodule

// File: rtl/scaled_rtc.sv
`timescale 1ns/1ps
module scaled_rtc
   import scaled_rtc_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int COUNT_W       = 64,
   parameter int SCALE_W       = 4,
   parameter int ADDR_W        = 8,
   parameter bit USE_LOG_SHIFT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   generate
      if (DATA_W <= int'(CFG_PEND_BIT)) begin : g_chk_data
         $error("scaled_rtc: data word too narrow for the pending flag");
      end
   endgenerate

   reg_sel_e           sel;
   logic [SCALE_W-1:0] scale;
   logic               run;
   logic [DATA_W-1:0]  cmp;
   logic [COUNT_W-1:0] count;
   logic [DATA_W-1:0]  scaled;
   logic               match;
   logic               inc;

   scaled_rtc_decode #(.ADDR_W(ADDR_W)) i_decode (
      .addr_i (bus_addr_i),
      .sel_o  (sel)
   );

   scaled_rtc_ctrl #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) i_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_we_i (bus_wr_i && sel == SEL_CFG),
      .cmp_we_i (bus_wr_i && sel == SEL_CMP),
      .wdata_i  (bus_wdata_i),
      .scale_o  (scale),
      .run_o    (run),
      .cmp_o    (cmp)
   );

   assign inc = run & tick_i;

   scaled_rtc_count #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) i_count (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lo_we_i (bus_wr_i && sel == SEL_CNT_LO),
      .hi_we_i (bus_wr_i && sel == SEL_CNT_HI),
      .inc_i   (inc),
      .wdata_i (bus_wdata_i),
      .count_o (count)
   );

   scaled_rtc_scale #(
      .DATA_W        (DATA_W),
      .COUNT_W       (COUNT_W),
      .SCALE_W       (SCALE_W),
      .USE_LOG_SHIFT (USE_LOG_SHIFT)
   ) i_scale (
      .count_i  (count),
      .scale_i  (scale),
      .cmp_i    (cmp),
      .scaled_o (scaled),
      .match_o  (match)
   );

   assign irq_o = match;

   always_comb begin
      bus_rdata_o = '0;
      case (sel)
         SEL_CFG: begin
            bus_rdata_o[SCALE_W-1:0]  = scale;
            bus_rdata_o[CFG_RUN_BIT]  = run;
            bus_rdata_o[CFG_PEND_BIT] = match;
         end
         SEL_CNT_LO: bus_rdata_o = count[DATA_W-1:0];
         SEL_CNT_HI: bus_rdata_o = count[COUNT_W-1:DATA_W];
         SEL_SCALED: bus_rdata_o = scaled;
         SEL_CMP:    bus_rdata_o = cmp;
         default:    bus_rdata_o = '0;
      endcase
   end

   // R2
   pend_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == SEL_CFG) |-> (bus_rdata_o[CFG_PEND_BIT] == irq_o));

   // R9
   irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && bus_wr_i && sel == SEL_CMP && !inc && bus_wdata_i > scaled) |=> !irq_o);

   // R7 R10
   no_side_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && (sel == SEL_SCALED || sel == SEL_NONE) && !inc)
         |=> ($stable(count) && $stable(cmp) && $stable(scale) && $stable(run)));

endmodule

// File: tb/test_scaled_rtc.sv
`timescale 1ns/1ps
module test_scaled_rtc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   // scoreboard queues: kind 0 = read data, kind 1 = interrupt level
   int          kind_q [$];
   logic [31:0] exp_q  [$];
   string       tag_q  [$];

   always #2 clk = ~clk;   // 250 MHz

   scaled_rtc i_scaled_rtc (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_i      (tick),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_o       (irq)
   );

   // monitor: pops expected items and compares away from the rising edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (kind_q.size() > 0) begin
            int          k;
            logic [31:0] e;
            string       t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (k == 0) begin
               if (bus_rdata !== e) begin
                  errors++;
                  $display("FAIL %s: read data actual 0x%08h expected 0x%08h", t, bus_rdata, e);
               end
            end else begin
               if (irq !== e[0]) begin
                  errors++;
                  $display("FAIL %s: irq actual %0b expected %0b", t, irq, e[0]);
               end
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      bus_addr = a;
      kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
   endtask

   task automatic irq_is(input logic e, input string t);
      @(negedge clk);
      kind_q.push_back(1); exp_q.push_back({31'd0, e}); tag_q.push_back(t);
   endtask

   task automatic finish_run;
      @(negedge clk);
      #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset contents, R10 unmapped read
      rd(8'h40, 32'h0000_0000, "R1 cfg");
      rd(8'h48, 32'h0000_0000, "R1 count lo");
      rd(8'h4C, 32'h0000_0000, "R1 count hi");
      rd(8'h50, 32'h0000_0000, "R1 scaled");
      rd(8'h60, 32'hFFFF_FFFF, "R1 cmp");
      irq_is(1'b0, "R1 irq");
      rd(8'h44, 32'h0000_0000, "R10 unmapped read");

      // R2 only scale, run and pending are visible
      wr(8'h40, 32'hFFFF_FFFF);
      rd(8'h40, 32'h0000_100F, "R2 cfg fields");
      wr(8'h40, 32'h0000_0000);

      // R3 ticks while stopped do nothing
      pulse(2);
      rd(8'h48, 32'h0000_0000, "R3 stopped hold");

      // R4 word access
      wr(8'h4C, 32'h1234_5678);
      wr(8'h48, 32'h9ABC_DEF0);
      rd(8'h4C, 32'h1234_5678, "R4 hi");
      rd(8'h48, 32'h9ABC_DEF0, "R4 lo");

      // R3 running count
      wr(8'h40, 32'h0000_1000);
      pulse(3);
      rd(8'h48, 32'h9ABC_DEF3, "R3 three ticks");
      rd(8'h4C, 32'h1234_5678, "R3 hi unchanged");
      rd(8'h48, 32'h9ABC_DEF3, "R3 no tick hold");

      // R5 write beats increment
      wr_tick(8'h48, 32'h0000_0010);
      rd(8'h48, 32'h0000_0010, "R5 lo write wins");
      rd(8'h4C, 32'h1234_5678, "R5 hi kept");
      wr_tick(8'h4C, 32'h0000_0001);
      rd(8'h4C, 32'h0000_0001, "R5 hi write wins");
      rd(8'h48, 32'h0000_0010, "R5 lo kept");

      // R6 wrap from all ones
      wr(8'h40, 32'h0000_0000);
      wr(8'h4C, 32'hFFFF_FFFF);
      wr(8'h48, 32'hFFFF_FFFF);
      wr(8'h40, 32'h0000_1000);
      irq_is(1'b1, "R8 all ones reaches cmp");
      pulse(1);
      rd(8'h48, 32'h0000_0000, "R6 wrap lo");
      rd(8'h4C, 32'h0000_0000, "R6 wrap hi");
      irq_is(1'b0, "R9 count lowered by wrap");

      // R7 scaled window
      wr(8'h40, 32'h0000_0000);
      wr(8'h4C, 32'h0000_0001);
      wr(8'h48, 32'h8000_0000);
      wr(8'h40, 32'h0000_0004);
      rd(8'h50, 32'h1800_0000, "R7 scale 4");
      wr(8'h50, 32'hDEAD_BEEF);
      rd(8'h50, 32'h1800_0000, "R7 write ignored scaled");
      rd(8'h48, 32'h8000_0000, "R7 write ignored count");
      wr(8'h40, 32'h0000_000F);
      rd(8'h50, 32'h0003_0000, "R7 scale 15");

      // R8 compare at scale 4
      wr(8'h40, 32'h0000_0004);
      wr(8'h60, 32'h1800_0001);
      irq_is(1'b0, "R8 below threshold");
      rd(8'h60, 32'h1800_0001, "R8 cmp readback");
      wr(8'h60, 32'h1800_0000);
      irq_is(1'b1, "R8 equal threshold");
      rd(8'h40, 32'h1000_0004, "R2 pending flag set");
      wr(8'h40, 32'h0000_0004);
      rd(8'h40, 32'h1000_0004, "R2 pending not writable");

      // R9 clearing paths
      wr(8'h60, 32'h1800_0010);
      irq_is(1'b0, "R9 cmp raised");
      wr(8'h60, 32'h17FF_FFFF);
      irq_is(1'b1, "R8 above threshold");
      wr(8'h48, 32'h0000_0000);
      irq_is(1'b0, "R9 count lowered");

      // R8 ticks cross the threshold at scale 1
      wr(8'h40, 32'h0000_0001);
      wr(8'h4C, 32'h0000_0000);
      wr(8'h48, 32'h0000_0004);
      wr(8'h60, 32'h0000_0003);
      wr(8'h40, 32'h0000_1001);
      irq_is(1'b0, "R8 scaled 2 below 3");
      pulse(1);
      irq_is(1'b0, "R8 scaled still 2");
      pulse(1);
      irq_is(1'b1, "R8 scaled reaches 3");

      // R10 unmapped write
      wr(8'h40, 32'h0000_0001);
      wr(8'h44, 32'hFFFF_FFFF);
      wr(8'h7C, 32'hFFFF_FFFF);
      rd(8'h44, 32'h0000_0000, "R10 unmapped still zero");
      rd(8'h60, 32'h0000_0003, "R10 cmp kept");
      rd(8'h48, 32'h0000_0006, "R10 count kept");
      rd(8'h40, 32'h1000_0001, "R10 cfg kept");

      finish_run();
   end

endmodule